// File: doc/BRIEF.md
# Fourth-Order Sinc Decimation Filter

This block turns the one-bit density stream of a delta-sigma modulator into signed 24-bit conversion results. Each accepted input bit counts as +1 or -1. The stream passes through a fourth-order cascaded integrator-comb structure, which gives a (sin x / x)^4 response. The output is taken once per decimation period. The decimation ratio is a power of two chosen at run time. A ratio of 2^11 turns a 245.76 kHz modulator rate into 120 results per second. A ratio of 2^14 turns 225.28 kHz into 13.75 results per second.

A mode input selects one of two operating modes. In single-cycle operation the filter flushes itself after every result, so each result depends only on its own four periods of input. In continuous operation the state is kept, and a fresh result follows every period once the filter has settled. Ratio and mode are captured while the synchronous clear is high. The clear also empties every integrator and comb register.

Top module: `sinc4_decim`

## Requirements
- R1: After reset, `result_valid` is 0 and `result` is 0, and the configuration is ratio 2^MAX_LOG2 in continuous mode.
- R2: An accepted `bit_in` of 1 counts as +1 and a 0 counts as -1. A steady run of ones gives +8388607, which is the full scale of +2^23 saturated. A steady run of zeros gives -8388608. `result` is two's complement.
- R3: Let R = 2^k, let w be the coefficients of (1 + z^-1 + ... + z^-(R-1))^4, and let n be the number of samples accepted since the last clear, with n a multiple of R. The result at sample n is floor(sum_j w[j]*x[n-3-j] / 2^(4k-23)), saturated to the 24-bit range. Samples before the clear count as 0.
- R4: k is the `cfg_log2_ratio` value, raised to MIN_LOG2 (6) when smaller and lowered to MAX_LOG2 (14) when larger.
- R5: `cfg_log2_ratio` and `cfg_single` are sampled only in cycles where `clr` is high. Changes at other times do not alter the result timing or values.
- R6: After a clear or reset, no result appears before 4R samples have been accepted.
- R7: With `cfg_single` = 1, a result appears after every 4R accepted samples, and the whole filter state is flushed after each result.
- R8: With `cfg_single` = 0, after the first result a new result appears every R accepted samples, and the filter state is never flushed.
- R9: A cycle with `bit_valid` low accepts no sample, whatever `bit_in` is.
- R10: `clr` flushes all filter and period state in the cycle it is high. A sample offered in that same cycle is discarded.
- R11: `result_valid` is high for exactly one cycle, on the clock after the edge that accepts the period-ending sample. `result` changes only together with `result_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Synchronous flush; also loads ratio and mode |
| cfg_log2_ratio | input | 4 | log2 of the decimation ratio |
| cfg_single | input | 1 | 1 selects single-cycle mode, 0 selects continuous mode |
| bit_valid | input | 1 | Modulator sample enable |
| bit_in | input | 1 | Modulator output bit |
| result | output | 24 | Conversion result, two's complement |
| result_valid | output | 1 | One-cycle strobe for a new result |

## Verification
The bench drives both full-scale extremes. A design that let +2^23 wrap would report -8388608 where +8388607 is expected. A reference FIR built from the exact fourth-power weights checks random streams in both modes. A design that failed to flush in single-cycle mode would leak earlier samples into later results, and a design with a misaligned window would fail the bit-exact comparison. Each result is also checked for the exact cycle it arrives in. This catches designs that count idle cycles, emit before four settling periods, accept the sample offered during a clear, or adopt a ratio or mode change that arrives without a clear. Out-of-range ratio codes must land on the clamp limits. At the top limit, one result must arrive after exactly 65536 samples.

// File: rtl/sinc4_pkg.sv
package sinc4_pkg;

    // Number of integrator and comb stages (sinc to this power)
    localparam int SINC_ORDER = 4;

    typedef enum logic {
        MODE_CONT   = 1'b0,
        MODE_SINGLE = 1'b1
    } conv_mode_e;

endpackage

// File: rtl/sinc4_integ.sv
// Integrator cascade. Each stage adds the previous stage's registered value,
// so the chain adds a fixed three-sample delay but only one adder per path.
module sinc4_integ #(
    parameter int ACC_W = 58,
    parameter int ORDER = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             step,
    input  logic             bit_in,
    output logic [ACC_W-1:0] tail_next
);

    localparam logic [ACC_W-1:0] STEP_UP = ACC_W'(1);
    localparam logic [ACC_W-1:0] STEP_DN = '1;

    typedef struct packed {
        logic [ORDER-1:0][ACC_W-1:0] stg;
    } integ_t;

    integ_t st_d, st_q;
    logic [ACC_W-1:0] sum [ORDER];

    assign sum[0] = st_q.stg[0] + (bit_in ? STEP_UP : STEP_DN);

    for (genvar g = 1; g < ORDER; g++) begin : g_add
        assign sum[g] = st_q.stg[g] + st_q.stg[g-1];
    end

    assign tail_next = sum[ORDER-1];

    always_comb begin
        st_d = st_q;
        if (flush) begin
            st_d = '0;
        end else if (step) begin
            for (int s = 0; s < ORDER; s++) begin
                st_d.stg[s] = sum[s];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

endmodule

// File: rtl/sinc4_comb.sv
// Comb cascade run at the decimated rate; differences wrap modulo 2^ACC_W.
module sinc4_comb #(
    parameter int ACC_W = 58,
    parameter int ORDER = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             fire,
    input  logic [ACC_W-1:0] din,
    output logic [ACC_W-1:0] dout
);

    typedef struct packed {
        logic [ORDER-1:0][ACC_W-1:0] dly;
    } comb_t;

    comb_t st_d, st_q;
    logic [ACC_W-1:0] diff [ORDER];

    assign diff[0] = din - st_q.dly[0];

    for (genvar g = 1; g < ORDER; g++) begin : g_sub
        assign diff[g] = diff[g-1] - st_q.dly[g];
    end

    assign dout = diff[ORDER-1];

    always_comb begin
        st_d = st_q;
        if (flush) begin
            st_d = '0;
        end else if (fire) begin
            st_d.dly[0] = din;
            for (int s = 1; s < ORDER; s++) begin
                st_d.dly[s] = diff[s-1];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

endmodule

// File: rtl/sinc4_scale.sv
// Arithmetic right shift to the output width, then clip to the signed range.
module sinc4_scale #(
    parameter int ACC_W = 58,
    parameter int OUT_W = 24,
    parameter int SH_W  = 6
) (
    input  logic [ACC_W-1:0] din,
    input  logic [SH_W-1:0]  shamt,
    output logic [OUT_W-1:0] dout
);

    localparam logic signed [ACC_W-1:0] POS_LIM =
        {{(ACC_W-OUT_W+1){1'b0}}, {(OUT_W-1){1'b1}}};
    localparam logic signed [ACC_W-1:0] NEG_LIM =
        {{(ACC_W-OUT_W+1){1'b1}}, {(OUT_W-1){1'b0}}};

    logic signed [ACC_W-1:0] shifted;

    assign shifted = $signed(din) >>> shamt;

    always_comb begin
        if (shifted > POS_LIM)      dout = POS_LIM[OUT_W-1:0];
        else if (shifted < NEG_LIM) dout = NEG_LIM[OUT_W-1:0];
        else                        dout = shifted[OUT_W-1:0];
    end

endmodule

// File: rtl/sinc4_decim.sv
module sinc4_decim
    import sinc4_pkg::*;
#(
    parameter int OUT_W    = 24,
    parameter int MIN_LOG2 = 6,
    parameter int MAX_LOG2 = 14
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              clr,
    input  logic [$clog2(MAX_LOG2+1)-1:0]     cfg_log2_ratio,
    input  logic                              cfg_single,
    input  logic                              bit_valid,
    input  logic                              bit_in,
    output logic [OUT_W-1:0]                  result,
    output logic                              result_valid
);

    localparam int ORDER = SINC_ORDER;
    localparam int ACC_W = ORDER * MAX_LOG2 + 2;
    localparam int SEL_W = $clog2(MAX_LOG2 + 1);
    localparam int CNT_W = MAX_LOG2;
    localparam int SH_W  = $clog2(ORDER * MAX_LOG2 + 1);

    typedef struct packed {
        logic [SEL_W-1:0] log2;
        conv_mode_e       mode;
        logic [CNT_W-1:0] phase;
        logic [1:0]       settle;
        logic [OUT_W-1:0] res;
        logic             vld;
    } ctl_t;

    localparam ctl_t CTL_RST = '{
        log2:   SEL_W'(MAX_LOG2),
        mode:   MODE_CONT,
        phase:  '0,
        settle: '0,
        res:    '0,
        vld:    1'b0
    };

    function automatic logic [SEL_W-1:0] clamp_log2(input logic [SEL_W-1:0] v);
        if (v < SEL_W'(MIN_LOG2))      return SEL_W'(MIN_LOG2);
        else if (v > SEL_W'(MAX_LOG2)) return SEL_W'(MAX_LOG2);
        else                           return v;
    endfunction

    ctl_t ctl_d, ctl_q;

    logic             step;
    logic             period_end;
    logic             emit;
    logic             flush;
    logic [CNT_W-1:0] phase_lim;
    logic [SH_W-1:0]  shamt;
    logic [ACC_W-1:0] integ_tail;
    logic [ACC_W-1:0] comb_out;
    logic [OUT_W-1:0] scaled;

    assign step       = bit_valid && !clr;
    assign phase_lim  = {CNT_W{1'b1}} >> (CNT_W - int'(ctl_q.log2));
    assign period_end = step && (ctl_q.phase == phase_lim);
    assign emit       = period_end && (ctl_q.settle == 2'd3);
    assign flush      = clr || (emit && (ctl_q.mode == MODE_SINGLE));
    assign shamt      = SH_W'(ORDER * int'(ctl_q.log2) - (OUT_W - 1));

    sinc4_integ #(.ACC_W(ACC_W), .ORDER(ORDER)) u_integ (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (flush),
        .step      (step),
        .bit_in    (bit_in),
        .tail_next (integ_tail)
    );

    sinc4_comb #(.ACC_W(ACC_W), .ORDER(ORDER)) u_comb (
        .clk   (clk),
        .rst_n (rst_n),
        .flush (flush),
        .fire  (period_end),
        .din   (integ_tail),
        .dout  (comb_out)
    );

    sinc4_scale #(.ACC_W(ACC_W), .OUT_W(OUT_W), .SH_W(SH_W)) u_scale (
        .din   (comb_out),
        .shamt (shamt),
        .dout  (scaled)
    );

    always_comb begin
        ctl_d     = ctl_q;
        ctl_d.vld = 1'b0;
        if (clr) begin
            ctl_d.log2   = clamp_log2(cfg_log2_ratio);
            ctl_d.mode   = conv_mode_e'(cfg_single);
            ctl_d.phase  = '0;
            ctl_d.settle = '0;
        end else if (step) begin
            ctl_d.phase = period_end ? '0 : ctl_q.phase + 1'b1;
            if (period_end) begin
                if (ctl_q.settle == 2'd3) begin
                    ctl_d.vld = 1'b1;
                    ctl_d.res = scaled;
                    if (ctl_q.mode == MODE_SINGLE) ctl_d.settle = '0;
                end else begin
                    ctl_d.settle = ctl_q.settle + 2'd1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= CTL_RST;
        else        ctl_q <= ctl_d;
    end

    assign result       = ctl_q.res;
    assign result_valid = ctl_q.vld;

endmodule

// File: rtl/sinc4_decim_chk.sv
module sinc4_decim_chk #(
    parameter int OUT_W = 24
) (
    input logic             clk,
    input logic             rst_n,
    input logic             clr,
    input logic             bit_valid,
    input logic [OUT_W-1:0] result,
    input logic             result_valid
);

    // R11: strobe never lasts two cycles (periods are at least 64 samples)
    a_r11_valid_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        result_valid |=> !result_valid);

    // R11: the result word moves only together with its strobe
    a_r11_result_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(result) |-> result_valid);

    // R9: a cycle without an accepted sample produces no result next cycle
    a_r9_idle_no_result: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_valid |=> !result_valid);

    // R10: a clear is never followed directly by a result
    a_r10_clear_silences: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> !result_valid);

endmodule

bind sinc4_decim sinc4_decim_chk #(.OUT_W(OUT_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .clr          (clr),
    .bit_valid    (bit_valid),
    .result       (result),
    .result_valid (result_valid)
);

// File: tb/tb_sinc4_decim.sv
module tb_sinc4_decim;

    localparam int OUT_W    = 24;
    localparam int MIN_LOG2 = 6;
    localparam int MAX_LOG2 = 14;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic clr = 1'b0;
    logic [3:0] cfg_log2_ratio = 4'd0;
    logic cfg_single = 1'b0;
    logic bit_valid = 1'b0;
    logic bit_in = 1'b0;
    logic [OUT_W-1:0] result;
    logic result_valid;

    always #5 clk = ~clk;

    sinc4_decim #(.OUT_W(OUT_W), .MIN_LOG2(MIN_LOG2), .MAX_LOG2(MAX_LOG2)) dut (
        .clk(clk), .rst_n(rst_n), .clr(clr), .cfg_log2_ratio(cfg_log2_ratio),
        .cfg_single(cfg_single), .bit_valid(bit_valid), .bit_in(bit_in),
        .result(result), .result_valid(result_valid)
    );

    int n_tests = 0;
    int n_fail = 0;
    longint cyc = 0;
    bit done = 1'b0;
    bit prev_valid = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    typedef struct {
        longint value;
        longint due;
        string  tag;
    } exp_t;

    exp_t   sb[$];
    int     hist[$];
    longint w[];
    int     m_R = 1;
    int     m_shift = 0;
    bit     m_single = 1'b0;
    int     m_cnt = 0;

    localparam longint POS_MAX = (longint'(1) << (OUT_W - 1)) - 1;
    localparam longint NEG_MIN = -(longint'(1) << (OUT_W - 1));

    function automatic void check(bit ok, string tag, longint got, longint exp_v);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, got, exp_v);
        end
    endfunction

    // Weights of the fourth power of an R-tap boxcar, by repeated running sums
    function automatic void build_w(int R);
        longint cur[];
        longint nxt[];
        longint run;
        cur = new[1];
        cur[0] = 1;
        for (int st = 0; st < 4; st++) begin
            nxt = new[cur.size() + R - 1];
            run = 0;
            for (int j = 0; j < nxt.size(); j++) begin
                if (j < cur.size()) run += cur[j];
                if (j - R >= 0 && j - R < cur.size()) run -= cur[j - R];
                nxt[j] = run;
            end
            cur = nxt;
        end
        w = cur;
    endfunction

    function automatic longint model_out();
        longint acc = 0;
        int n = hist.size();
        for (int j = 0; j < w.size(); j++) acc += w[j] * longint'(hist[n - 4 - j]);
        acc = acc >>> m_shift;
        if (acc > POS_MAX) acc = POS_MAX;
        if (acc < NEG_MIN) acc = NEG_MIN;
        return acc;
    endfunction

    function automatic bit pat_bit(int pat, int i);
        case (pat)
            0: return 1'b1;
            1: return 1'b0;
            2: return i[0];
            3: return (i % 4) != 3;
            default: return 1'($urandom_range(0, 1));
        endcase
    endfunction

    // Offers one sample; pushes the expected result when it ends a period
    task automatic put(bit b, string tag);
        @(posedge clk);
        #1;
        bit_valid = 1'b1;
        bit_in = b;
        hist.push_back(b ? 1 : -1);
        m_cnt++;
        if (m_cnt % m_R == 0 && m_cnt / m_R >= 4) begin
            sb.push_back('{model_out(), cyc + 1, tag});
            if (m_single) begin
                m_cnt = 0;
                hist.delete();
            end
        end
    endtask

    // Idle cycles with a toggling bit that must be ignored (R9)
    task automatic idle(int k);
        for (int i = 0; i < k; i++) begin
            @(posedge clk);
            #1;
            bit_valid = 1'b0;
            bit_in = ~bit_in;
        end
    endtask

    task automatic stream(int n, int pat, int gap_every, string tag);
        for (int i = 0; i < n; i++) begin
            put(pat_bit(pat, i), tag);
            if (gap_every > 0 && (i % gap_every) == gap_every - 1) idle(2);
        end
        idle(1);
    endtask

    task automatic do_clr(int k, bit single, bit with_sample);
        int eff;
        @(posedge clk);
        #1;
        clr = 1'b1;
        cfg_log2_ratio = 4'(k);
        cfg_single = single;
        bit_valid = with_sample;
        bit_in = 1'b1;
        @(posedge clk);
        #1;
        clr = 1'b0;
        bit_valid = 1'b0;
        eff = (k < MIN_LOG2) ? MIN_LOG2 : ((k > MAX_LOG2) ? MAX_LOG2 : k);
        m_R = 1 << eff;
        m_shift = 4 * eff - (OUT_W - 1);
        m_single = single;
        m_cnt = 0;
        hist.delete();
        build_w(m_R);
    endtask

    task automatic drain(string tag);
        repeat (6) @(posedge clk);
        check(sb.size() == 0, tag, sb.size(), 0);
        sb.delete();
    endtask

    // Scoreboard monitor: value and arrival cycle of every result (R11)
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (result_valid) begin
                if (prev_valid) check(1'b0, "R11 strobe longer than one cycle", 1, 0);
                if (sb.size() == 0) begin
                    check(1'b0, "R6/R7/R8 unexpected result", longint'($signed(result)), 0);
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    check(longint'($signed(result)) == e.value, e.tag,
                          longint'($signed(result)), e.value);
                    check(cyc == e.due, {e.tag, " R11 arrival cycle"}, cyc, e.due);
                end
            end else if (sb.size() > 0 && cyc > sb[0].due) begin
                check(1'b0, {sb[0].tag, " R11 missing result"}, 0, sb[0].value);
                void'(sb.pop_front());
            end
            prev_valid = result_valid;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R1: reset state
        check(result_valid == 1'b0, "R1 valid after reset", result_valid, 0);
        check(result == '0, "R1 result after reset", result, 0);
        rst_n = 1'b1;
        repeat (2) @(posedge clk);
        #1;
        check(result_valid == 1'b0 && result == '0, "R1 idle after release", result, 0);

        do_clr(6, 1'b0, 1'b0);
        stream(256 + 128, 0, 0, "R2 positive full scale saturates");
        drain("R2 drain");

        do_clr(7, 1'b0, 1'b0);
        stream(512 + 256, 1, 0, "R2 negative full scale");
        drain("R2 drain negative");

        do_clr(6, 1'b0, 1'b0);
        stream(640, 3, 0, "R3 three-quarter density");
        drain("R3 drain");

        do_clr(6, 1'b0, 1'b0);
        stream(64 * 10, 4, 5, "R8/R9 continuous random with idle gaps");
        drain("R8 drain");

        do_clr(6, 1'b1, 1'b0);
        stream(64 * 12, 4, 7, "R7 single-cycle random");
        drain("R7 drain");

        do_clr(6, 1'b0, 1'b0);
        stream(200, 2, 0, "R5 before config change");
        cfg_log2_ratio = 4'd9;
        cfg_single = 1'b1;
        stream(500, 4, 3, "R5 config change without clear ignored");
        drain("R5 drain");

        do_clr(6, 1'b0, 1'b1);
        stream(100, 0, 0, "R10 partial period");
        do_clr(6, 1'b0, 1'b1);
        stream(300, 4, 0, "R10 clear flushes and drops its sample");
        drain("R10 drain");

        do_clr(3, 1'b1, 1'b0);
        stream(512, 4, 0, "R4 low ratio clamps up");
        drain("R4 drain low");

        do_clr(15, 1'b1, 1'b0);
        stream(65536, 0, 0, "R4/R6 high ratio clamps down");
        drain("R4 drain high");

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (195000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual hung run expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule